// File: doc/BRIEF.md
# Program Counter Sequencer with Bit-Test Skip and Subroutine Call

This block holds the 11-bit program counter of a small accumulator-style controller core and decides, one cycle at a time, where the next fetch goes. Each cycle an instruction is fetched at `fetch_addr` while the instruction fetched one cycle earlier is in its execute slot. The decoder drives one control bundle for that executing instruction: a bit-test-and-skip request with the operand byte and a bit index, or a subroutine call with an 8-bit target and two page bits taken from the status register.

In the plain flow the counter steps by one and wraps from 0x7FF to 0x000. A taken skip leaves the counter stepping, but flags the instruction that is already fetched so it runs as a NOP. A call jumps to a target built from the page bits, a zero and the immediate. It pushes the return address onto a two-entry hardware stack, and the prefetched instruction runs as a NOP. While `nop_slot` is high the execute slot holds such a NOP, and the bundle is ignored.

Top module: `program_sequencer`

## Requirements
- R1: A synchronous reset makes `fetch_addr` equal 0x7FF. It sets `nop_slot` high and clears both stack entries, `ret_top` and `ret_next`, to zero.
- R2: In a cycle with no call taken, `fetch_addr` advances by one at the next edge, and 0x7FF wraps to 0x000.
- R3: A skip request in a valid slot is taken only when `tst_data[tst_idx]` is 1, with the index in 0 to 7. A taken skip sets `nop_slot` for the next cycle, and `fetch_addr` still advances by one. When the selected bit is 0 the next slot is valid.
- R4: A call in a valid slot loads `fetch_addr` with `{page_sel[1:0], 1'b0, imm[7:0]}`. `page_sel` fills bits 10:9, bit 8 is zero and `imm` fills bits 7:0.
- R5: A call pushes its return address onto `ret_top`. The return address is the call's own address plus one, which is the value `fetch_addr` had during the call.
- R6: On a push the old `ret_top` moves to `ret_next` and the old `ret_next` is lost. Without a push both entries hold.
- R7: The cycle after a call has `nop_slot` high, so a call takes two cycles.
- R8: While `nop_slot` is high, `ctl_skip`, `ctl_call` and their operands have no effect. There is no jump and no push, the count steps by one, and the next slot is valid.
- R9: If `ctl_call` and `ctl_skip` are both high in a valid slot, the call is carried out and the skip is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ctl_skip | input | 1 | Executing instruction is a bit-test-and-skip |
| ctl_call | input | 1 | Executing instruction is a subroutine call |
| tst_data | input | 8 | Operand byte for the bit test |
| tst_idx | input | 3 | Bit index into `tst_data` |
| imm | input | 8 | Call target low byte |
| page_sel | input | 2 | Page bits from the status register |
| fetch_addr | output | 11 | Current program counter / fetch address |
| nop_slot | output | 1 | Instruction now in execute is discarded and runs as NOP |
| ret_top | output | 11 | Top stack entry |
| ret_next | output | 11 | Second stack entry |

## Verification
The bench targets the wrap from 0x7FF to 0x000 right after reset. A counter missing that wrap jumps to 0x800-style garbage or sticks at the reset vector. It issues calls and skips inside NOP slots, where a design that ignored the slot would jump or push twice for one instruction. It issues back-to-back calls past the stack depth, which catches a stack that fails to shift or that keeps the oldest entry. It also drives call and skip together, and bit tests on every index with the bit both set and clear. The last two expose a wrong bit select, a skip on a zero bit, or a forced bit 8 left set.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int unsigned PC_W   = 11;
  localparam int unsigned IMM_W  = 8;
  localparam int unsigned PAGE_W = 2;
  localparam int unsigned DAT_W  = 8;
  localparam int unsigned IDX_W  = $clog2(DAT_W);

  typedef logic [PC_W-1:0]   pc_t;
  typedef logic [IMM_W-1:0]  imm_t;
  typedef logic [PAGE_W-1:0] page_t;

  // next sequential address, modulo program space
  function automatic pc_t pc_step(input pc_t cur);
    return cur + pc_t'(1);
  endfunction

  // page bits on top, one forced zero, then the immediate
  function automatic pc_t call_dest(input page_t pg, input imm_t k);
    return {pg, 1'b0, k};
  endfunction

  function automatic logic bit_pick(input logic [DAT_W-1:0] d,
                                    input logic [IDX_W-1:0] i);
    return d[i];
  endfunction
endpackage

// File: rtl/seq_skip_eval.sv
module seq_skip_eval
  import seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             slot_nop,
  input  logic             ctl_skip,
  input  logic             ctl_call,
  input  logic [DAT_W-1:0] tst_data,
  input  logic [IDX_W-1:0] tst_idx,
  output logic             call_go,
  output logic             skip_go
);
  logic slot_ok;
  logic bit_hit;

  always_comb begin
    slot_ok = !slot_nop;
    bit_hit = bit_pick(tst_data, tst_idx);
    call_go = slot_ok && ctl_call;
    skip_go = slot_ok && ctl_skip && !ctl_call && bit_hit;
  end

  // R3: a clear bit never produces a skip
  a_r3_clear_no_skip: assert property (@(posedge clk) disable iff (rst)
    (ctl_skip && !tst_data[tst_idx]) |-> !skip_go);
  // R8: a NOP slot launches nothing
  a_r8_nop_inert: assert property (@(posedge clk) disable iff (rst)
    slot_nop |-> (!call_go && !skip_go));
endmodule

// File: rtl/seq_pc_unit.sv
module seq_pc_unit
  import seq_pkg::*;
#(
  parameter pc_t RESET_VEC = '1
)(
  input  logic  clk,
  input  logic  rst,
  input  logic  call_go,
  input  logic  skip_go,
  input  page_t page_sel,
  input  imm_t  imm,
  output pc_t   pc_q,
  output logic  nop_q
);
  pc_t  pc_d;
  logic nop_d;

  always_comb begin
    pc_d  = call_go ? call_dest(page_sel, imm) : pc_step(pc_q);
    nop_d = call_go || skip_go;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= RESET_VEC;
      nop_q <= 1'b1;
    end else begin
      pc_q  <= pc_d;
      nop_q <= nop_d;
    end
  end

  // R2: no call means the count moves on by one
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    !call_go |=> (pc_q == pc_step($past(pc_q))));
  // R4: call target bit 8 is zero and page bits land on top
  a_r4_page: assert property (@(posedge clk) disable iff (rst)
    call_go |=> (pc_q[8] == 1'b0 && pc_q[10:9] == $past(page_sel)));
  // R7: a call is followed by a discarded slot
  a_r7_call_nop: assert property (@(posedge clk) disable iff (rst)
    call_go |=> nop_q);
  // R3: taken skip discards the next slot
  a_r3_skip_nop: assert property (@(posedge clk) disable iff (rst)
    skip_go |=> nop_q);
endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack
  import seq_pkg::*;
#(
  parameter int unsigned DEPTH = 2
)(
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  pc_t  push_val,
  output pc_t  top,
  output pc_t  second
);
  pc_t ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)       ent[g] <= '0;
        else if (push) ent[g] <= push_val;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst)       ent[g] <= '0;
        else if (push) ent[g] <= ent[g-1];
      end
    end
  end

  assign top    = ent[0];
  assign second = ent[1];

  // R5: pushed value appears on top
  a_r5_push: assert property (@(posedge clk) disable iff (rst)
    push |=> (top == $past(push_val)));
  // R6: old top shifts down on push, entries hold otherwise
  a_r6_shift: assert property (@(posedge clk) disable iff (rst)
    push |=> (second == $past(top)));
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !push |=> ($stable(top) && $stable(second)));
endmodule

// File: rtl/program_sequencer.sv
module program_sequencer
  import seq_pkg::*;
#(
  parameter int unsigned STK_DEPTH = 2,
  parameter logic [10:0] RESET_VEC = 11'h7FF
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        ctl_skip,
  input  logic        ctl_call,
  input  logic [7:0]  tst_data,
  input  logic [2:0]  tst_idx,
  input  logic [7:0]  imm,
  input  logic [1:0]  page_sel,
  output logic [10:0] fetch_addr,
  output logic        nop_slot,
  output logic [10:0] ret_top,
  output logic [10:0] ret_next
);
  logic call_go;
  logic skip_go;
  pc_t  pc_q;
  logic nop_q;
  pc_t  ret_addr;

  seq_skip_eval u_eval (
    .clk      (clk),
    .rst      (rst),
    .slot_nop (nop_q),
    .ctl_skip (ctl_skip),
    .ctl_call (ctl_call),
    .tst_data (tst_data),
    .tst_idx  (tst_idx),
    .call_go  (call_go),
    .skip_go  (skip_go)
  );

  seq_pc_unit #(.RESET_VEC(RESET_VEC)) u_pc (
    .clk      (clk),
    .rst      (rst),
    .call_go  (call_go),
    .skip_go  (skip_go),
    .page_sel (page_sel),
    .imm      (imm),
    .pc_q     (pc_q),
    .nop_q    (nop_q)
  );

  // in a valid slot the fetch counter already holds call address + 1
  assign ret_addr = pc_q;

  seq_ret_stack #(.DEPTH(STK_DEPTH)) u_stk (
    .clk      (clk),
    .rst      (rst),
    .push     (call_go),
    .push_val (ret_addr),
    .top      (ret_top),
    .second   (ret_next)
  );

  assign fetch_addr = pc_q;
  assign nop_slot   = nop_q;

  // R8: a discarded slot is always followed by a valid one
  a_r8_single_nop: assert property (@(posedge clk) disable iff (rst)
    nop_slot |=> !nop_slot);
  // R9: call beats skip when both are requested
  a_r9_call_wins: assert property (@(posedge clk) disable iff (rst)
    (!nop_slot && ctl_call && ctl_skip) |=> (fetch_addr == call_dest($past(page_sel), $past(imm))));
  // R1: reset lands on the reset vector with a discarded slot
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (fetch_addr == RESET_VEC && nop_slot));
endmodule

// File: tb/program_sequencer_bench.sv
`timescale 1ns/1ps
module program_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_skip = 1'b0, ctl_call = 1'b0;
  logic [7:0]  tst_data = '0, imm = '0;
  logic [2:0]  tst_idx = '0;
  logic [1:0]  page_sel = '0;
  logic [10:0] fetch_addr, ret_top, ret_next;
  logic        nop_slot;

  int n_vec = 0, n_bad = 0;
  logic [10:0] m_pc, m_prev, m_s0, m_s1;
  logic        m_nop;
  string       t_pc, t_nop;

  always #2.5 clk = ~clk;

  program_sequencer u_program_sequencer (
    .clk(clk), .rst(rst), .ctl_skip(ctl_skip), .ctl_call(ctl_call),
    .tst_data(tst_data), .tst_idx(tst_idx), .imm(imm), .page_sel(page_sel),
    .fetch_addr(fetch_addr), .nop_slot(nop_slot),
    .ret_top(ret_top), .ret_next(ret_next)
  );

  function automatic logic [10:0] exp_target(input logic [1:0] p, input logic [7:0] k);
    logic [10:0] t;
    t[10:9] = p;
    t[8]    = 1'b0;
    t[7:0]  = k;
    return t;
  endfunction

  task automatic chk(input string tag, input logic [10:0] act, input logic [10:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(t_pc, fetch_addr, m_pc);
    chk(t_nop, {10'b0, nop_slot}, {10'b0, m_nop});
    chk("R5 top", ret_top, m_s0);
    chk("R6 next", ret_next, m_s1);
  endtask

  task automatic do_reset();
    rst = 1'b1; ctl_skip = 1'b0; ctl_call = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    m_pc = 11'h7FF; m_prev = 11'h7FF; m_nop = 1'b1; m_s0 = '0; m_s1 = '0;
    t_pc = "R1"; t_nop = "R1";
    compare_all();
    rst = 1'b0;
  endtask

  task automatic step(input logic sk, input logic cl, input logic [7:0] d,
                      input logic [2:0] ix, input logic [7:0] k, input logic [1:0] p);
    logic valid, cg, sg;
    ctl_skip = sk; ctl_call = cl; tst_data = d; tst_idx = ix; imm = k; page_sel = p;
    valid = !m_nop;
    cg = valid && cl;
    sg = valid && !cl && sk && ((d >> ix) & 8'd1) != 8'd0;
    if (!valid && (sk || cl)) t_pc = "R8";
    else if (cg && sk)        t_pc = "R9";
    else if (cg)              t_pc = "R4";
    else if (valid && sk)     t_pc = "R3";
    else                      t_pc = "R2";
    t_nop = cg ? "R7" : t_pc;
    if (cg) begin
      m_s1 = m_s0;
      m_s0 = m_prev + 11'd1;   // call's own address plus one
    end
    m_prev = m_pc;
    m_pc   = cg ? exp_target(p, k) : m_pc + 11'd1;
    m_nop  = cg || sg;
    @(posedge clk); @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(200000 * 5.0);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    do_reset();                                          // R1
    step(1'b0, 1'b1, 8'h00, 3'd0, 8'h55, 2'b11);         // R8 call in NOP slot, R2 wrap to 0
    step(1'b0, 1'b0, 8'h00, 3'd0, 8'h00, 2'b00);         // R2
    for (int b = 0; b < 8; b++) begin
      step(1'b1, 1'b0, ~(8'd1 << b), 3'(b), 8'h00, 2'b00); // R3 clear bit, no skip
      step(1'b1, 1'b0, 8'd1 << b, 3'(b), 8'h00, 2'b00);    // R3 set bit, skip
      step(1'b1, 1'b1, 8'hFF, 3'(b), 8'hAA, 2'b01);        // R8 request in NOP slot
    end
    step(1'b0, 1'b1, 8'h00, 3'd0, 8'h12, 2'b10);         // R4 R5
    step(1'b0, 1'b0, 8'h00, 3'd0, 8'h00, 2'b00);         // R7 NOP slot
    step(1'b0, 1'b1, 8'h00, 3'd0, 8'hFF, 2'b11);         // R6 second push
    step(1'b0, 1'b0, 8'h00, 3'd0, 8'h00, 2'b00);
    step(1'b0, 1'b1, 8'h00, 3'd0, 8'h00, 2'b01);         // R6 overflow drops oldest
    step(1'b0, 1'b0, 8'h00, 3'd0, 8'h00, 2'b00);
    step(1'b1, 1'b1, 8'hFF, 3'd5, 8'h3C, 2'b00);         // R9 call wins
    step(1'b0, 1'b0, 8'h00, 3'd0, 8'h00, 2'b00);
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r == 0) begin
        do_reset();
      end else begin
        step(r < 35, (r >= 30 && r < 48), 8'($urandom), 3'($urandom),
             8'($urandom), 2'($urandom));
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule